// File: doc/BRIEF.md
# Fixed Off-Time Decay Sequencer

This block is the digital timing core of a chopping current regulator for a full-bridge motor driver. While the bridge drives the winding, the current rises until an external comparator reports that it has reached the trip level. The block then clears its source-drive flag and holds the bridge off for a fixed number of oscillator ticks. During that interval it tells the gate logic whether the recirculating current is decaying fast or slow. A 2-bit decay code picks the share of the interval spent in fast decay, so slow, mixed and fast decay are all available.

When the off interval ends, the source drive comes back and a comparator blanking window opens. This masks the switching spike that follows turn-on. The same window is restarted whenever the direction input toggles or the external enable rises. All timing runs on the system clock and advances only on a single-cycle oscillator tick.

Top module: `offtime_decay_seq`

## Requirements
- R1: After reset, `src_en` is 1, `decay_fast` is 0 and `blanking` is 0, and the remembered previous values of `phase` and `enable` are both 0.
- R2: A `trip` sampled high at a clock edge while `src_en` is 1 and `blanking` is 0 clears `src_en` at that edge and starts the off interval with zero ticks counted.
- R3: The off interval ends at the edge that registers the 96th `osc_tick` after the trip edge; a tick in the trip cycle itself is not counted. `src_en` returns to 1 at that edge.
- R4: During the off interval, `decay_fast` is 1 while fewer than F ticks have been counted, and 0 afterwards. F is set by `decay_sel`: 2'b00 gives 0 (all slow), 2'b01 gives 14, 2'b10 gives 46 and 2'b11 gives 96 (all fast). `decay_sel` is read live. `decay_fast` is 0 whenever `src_en` is 1.
- R5: A `trip` during the off interval is ignored: the interval is neither restarted nor extended.
- R6: At the edge where the off interval ends, `blanking` rises and stays 1 for 6 ticks when `blank_sel` is 0, or 12 ticks when it is 1. `blank_sel` is sampled when the window is loaded.
- R7: A `trip` while `blanking` is 1 leaves `src_en` at 1.
- R8: A change of `phase` from its value in the previous clock cycle reloads the blanking window at the next edge.
- R9: A rising edge of `enable` reloads the blanking window at the next edge. A falling edge does not start a window.
- R10: Counters advance only on clock edges where `osc_tick` is 1. Without ticks, the off interval and the blanking window hold indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle oscillator tick pulse |
| trip | input | 1 | Sense comparator output, high at trip level |
| decay_sel | input | 2 | Fast-decay share code for the off interval |
| blank_sel | input | 1 | Blanking length select: 0 short, 1 long |
| phase | input | 1 | Direction input; any change restarts blanking |
| enable | input | 1 | External enable; a rising edge restarts blanking |
| src_en | output | 1 | Source-drive enable flag |
| decay_fast | output | 1 | 1 for fast decay, 0 for slow decay during the off interval |
| blanking | output | 1 | Comparator blanking window active |

## Verification
The trip response, the end of the off interval and the reload of the blanking window on a `phase` or `enable` event each appear one edge after the input is sampled. `decay_fast` and `blanking` follow the tick counts with no extra delay once the counting edge has passed. The bench drives each input on a falling clock edge, spaces ticks two clocks apart, and samples at the falling edge that follows the counting edge. This lets every expected value be stated as an exact tick count: 96 for the off interval, 14 or 46 for the fast share, and 6 or 12 for blanking. Each boundary is probed one tick before and at the exact tick.

// File: rtl/offtime_pkg.sv
package offtime_pkg;
    typedef enum logic {
        ST_DRIVE = 1'b0,
        ST_OFF   = 1'b1
    } drv_state_e;

    typedef enum logic [1:0] {
        DK_SLOW  = 2'b00,
        DK_MIXLO = 2'b01,
        DK_MIXHI = 2'b10,
        DK_FAST  = 2'b11
    } decay_code_e;
endpackage

// File: rtl/offtime_ctrl.sv
module offtime_ctrl
    import offtime_pkg::*;
#(
    parameter int OFF_TICKS = 96,
    parameter int FAST_LO   = 14,
    parameter int FAST_HI   = 46,
    localparam int CW       = $clog2(OFF_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trip_ok,
    input  logic [1:0] decay_sel,
    output logic       src_en,
    output logic       decay_fast,
    output logic       off_done
);
    typedef struct packed {
        drv_state_e    st;
        logic [CW-1:0] cnt;
    } regs_t;

    regs_t         r_d, r_q;
    logic [CW-1:0] fast_len;

    always_comb begin
        r_d      = r_q;
        off_done = 1'b0;
        unique case (decay_code_e'(decay_sel))
            DK_SLOW:  fast_len = '0;
            DK_MIXLO: fast_len = CW'(FAST_LO);
            DK_MIXHI: fast_len = CW'(FAST_HI);
            default:  fast_len = CW'(OFF_TICKS);
        endcase
        if (r_q.st == ST_DRIVE) begin
            if (trip_ok) begin
                r_d.st  = ST_OFF;
                r_d.cnt = '0;
            end
        end else if (tick) begin
            if (r_q.cnt == CW'(OFF_TICKS - 1)) begin
                r_d.st   = ST_DRIVE;
                r_d.cnt  = '0;
                off_done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
        src_en     = (r_q.st == ST_DRIVE);
        decay_fast = (r_q.st == ST_OFF) && (r_q.cnt < fast_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_DRIVE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2
    trip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DRIVE && trip_ok) |=> (r_q.st == ST_OFF && r_q.cnt == '0));

    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OFF && r_q.cnt != CW'(OFF_TICKS - 1)) |=> (r_q.st == ST_OFF));

    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OFF && !tick) |=> $stable(r_q.cnt));

    // R4
    drive_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_en |-> !decay_fast);

    // R4
    full_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decay_sel == 2'b11 && !src_en) |-> decay_fast);
endmodule

// File: rtl/blank_ctrl.sv
module blank_ctrl #(
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12,
    localparam int BW         = $clog2(BLANK_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic blank_sel,
    output logic blanking
);
    typedef struct packed {
        logic [BW-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.cnt = blank_sel ? BW'(BLANK_LONG) : BW'(BLANK_SHORT);
        end else if (tick && r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        blanking = (r_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R6
    blank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> blanking);

    // R6
    blank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= BW'(BLANK_LONG));

    // R10
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(r_q.cnt));
endmodule

// File: rtl/event_detect.sv
module event_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic phase,
    input  logic enable,
    output logic restart
);
    typedef struct packed {
        logic phase;
        logic enable;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d.phase  = phase;
        r_d.enable = enable;
        restart    = (phase ^ r_q.phase) | (enable & ~r_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase  <= 1'b0;
            r_q.enable <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R9
    enable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.enable && !enable && phase == r_q.phase) |-> !restart);
endmodule

// File: rtl/offtime_decay_seq.sv
module offtime_decay_seq #(
    parameter int OFF_TICKS   = 96,
    parameter int FAST_LO     = 14,
    parameter int FAST_HI     = 46,
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       trip,
    input  logic [1:0] decay_sel,
    input  logic       blank_sel,
    input  logic       phase,
    input  logic       enable,
    output logic       src_en,
    output logic       decay_fast,
    output logic       blanking
);
    logic trip_ok;
    logic off_done;
    logic restart;
    logic blank_start;

    assign trip_ok     = trip & ~blanking;
    assign blank_start = off_done | restart;

    offtime_ctrl #(
        .OFF_TICKS (OFF_TICKS),
        .FAST_LO   (FAST_LO),
        .FAST_HI   (FAST_HI)
    ) u_off (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (osc_tick),
        .trip_ok    (trip_ok),
        .decay_sel  (decay_sel),
        .src_en     (src_en),
        .decay_fast (decay_fast),
        .off_done   (off_done)
    );

    blank_ctrl #(
        .BLANK_SHORT (BLANK_SHORT),
        .BLANK_LONG  (BLANK_LONG)
    ) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (osc_tick),
        .start     (blank_start),
        .blank_sel (blank_sel),
        .blanking  (blanking)
    );

    event_detect u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .enable  (enable),
        .restart (restart)
    );

    // R7
    blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blanking && src_en && trip) |=> src_en);

    // R6
    reopen_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && off_done) |=> (src_en && blanking));
endmodule

// File: tb/offtime_decay_seq_test.sv
module offtime_decay_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       trip = 1'b0;
    logic [1:0] decay_sel = 2'b00;
    logic       blank_sel = 1'b0;
    logic       phase = 1'b0;
    logic       enable = 1'b0;
    logic       src_en, decay_fast, blanking;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    offtime_decay_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .trip       (trip),
        .decay_sel  (decay_sel),
        .blank_sel  (blank_sel),
        .phase      (phase),
        .enable     (enable),
        .src_en     (src_en),
        .decay_fast (decay_fast),
        .blanking   (blanking)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_trip();
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "src_en", src_en, 1'b1);
        check("R1", "decay_fast", decay_fast, 1'b0);
        check("R1", "blanking", blanking, 1'b0);
        do_tick(20);
        check("R10", "idle ticks keep src_en", src_en, 1'b1);
    endtask

    task automatic t_slow();
        decay_sel = 2'b00;
        blank_sel = 1'b0;
        pulse_trip();
        check("R2", "src_en after trip", src_en, 1'b0);
        check("R4", "slow code decay", decay_fast, 1'b0);
        do_tick(95);
        check("R3", "src_en at 95 ticks", src_en, 1'b0);
        do_tick(1);
        check("R3", "src_en at 96 ticks", src_en, 1'b1);
        check("R6", "blanking at reopen", blanking, 1'b1);
        do_tick(5);
        check("R6", "short blank at 5", blanking, 1'b1);
        do_tick(1);
        check("R6", "short blank at 6", blanking, 1'b0);
    endtask

    task automatic t_mix_lo();
        decay_sel = 2'b01;
        blank_sel = 1'b1;
        pulse_trip();
        check("R4", "mix15 start fast", decay_fast, 1'b1);
        do_tick(13);
        check("R4", "mix15 at 13", decay_fast, 1'b1);
        do_tick(1);
        check("R4", "mix15 at 14", decay_fast, 1'b0);
        do_tick(82);
        check("R3", "mix15 reopen", src_en, 1'b1);
        do_tick(11);
        check("R6", "long blank at 11", blanking, 1'b1);
        do_tick(1);
        check("R6", "long blank at 12", blanking, 1'b0);
    endtask

    task automatic t_mix_hi();
        decay_sel = 2'b10;
        blank_sel = 1'b1;
        pulse_trip();
        do_tick(45);
        check("R4", "mix48 at 45", decay_fast, 1'b1);
        do_tick(1);
        check("R4", "mix48 at 46", decay_fast, 1'b0);
        check("R4", "mix48 still off", src_en, 1'b0);
        do_tick(50);
        check("R3", "mix48 reopen", src_en, 1'b1);
        do_tick(12);
    endtask

    task automatic t_fast();
        decay_sel = 2'b11;
        blank_sel = 1'b0;
        pulse_trip();
        do_tick(95);
        check("R4", "fast at 95", decay_fast, 1'b1);
        do_tick(1);
        check("R3", "fast reopen", src_en, 1'b1);
        check("R4", "decay flag cleared on drive", decay_fast, 1'b0);
        do_tick(6);
    endtask

    task automatic t_ignore();
        decay_sel = 2'b00;
        blank_sel = 1'b0;
        pulse_trip();
        do_tick(50);
        pulse_trip();
        do_tick(45);
        check("R5", "no retrigger at 95", src_en, 1'b0);
        do_tick(1);
        check("R5", "no retrigger end at 96", src_en, 1'b1);
        pulse_trip();
        check("R7", "trip during blank", src_en, 1'b1);
        do_tick(6);
        check("R6", "blank over", blanking, 1'b0);
        pulse_trip();
        check("R2", "trip after blank", src_en, 1'b0);
        do_tick(96);
        do_tick(6);
    endtask

    task automatic t_no_tick();
        pulse_trip();
        repeat (300) @(negedge clk);
        check("R10", "off holds without ticks", src_en, 1'b0);
        do_tick(96);
        check("R10", "off ends after ticks", src_en, 1'b1);
        repeat (300) @(negedge clk);
        check("R10", "blank holds without ticks", blanking, 1'b1);
        do_tick(6);
    endtask

    task automatic t_phase();
        blank_sel = 1'b0;
        check("R8", "idle before phase", blanking, 1'b0);
        phase = ~phase;
        @(negedge clk);
        check("R8", "phase change blanks", blanking, 1'b1);
        pulse_trip();
        check("R7", "trip in phase blank", src_en, 1'b1);
        do_tick(5);
        check("R8", "phase blank at 5", blanking, 1'b1);
        do_tick(1);
        check("R8", "phase blank at 6", blanking, 1'b0);
    endtask

    task automatic t_enable();
        blank_sel = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check("R9", "enable rise blanks", blanking, 1'b1);
        do_tick(12);
        check("R9", "enable blank done", blanking, 1'b0);
        enable = 1'b0;
        @(negedge clk);
        check("R9", "enable fall no blank", blanking, 1'b0);
        @(negedge clk);
        check("R9", "enable fall still no blank", blanking, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slow();
        t_mix_lo();
        t_mix_hi();
        t_fast();
        t_ignore();
        t_no_tick();
        t_phase();
        t_enable();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule